// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether the header of a received CAN frame is accepted. The receive path hands over the four identifier bytes of a frame together with a one-cycle frame-valid strobe. The block compares them against eight acceptance-code bytes and eight mask bytes, held in two banks of four. A 2-bit mode input selects how the banks are divided: two wide filters that each cover all four identifier bytes, four half filters that each cover the first two identifier bytes, eight narrow filters that each cover only the first identifier byte, or a closed setting that rejects every frame.

One clock after the strobe the block raises an accept pulse, a matching receive-flag set request, and the index of the lowest-numbered filter that matched. Code and mask bytes are loaded through a simple write port. That port only takes effect while the init-mode input is high, so a running filter cannot be changed by a stray write.

The first identifier byte arrives in `id_word[7:0]` and the fourth in `id_word[31:24]`. For an extended frame the first two bytes carry the 14 most significant identifier bits plus SRR and IDE. For a standard frame they carry the 11 identifier bits plus RTR and IDE. This is why a half filter is enough to screen a standard frame completely.

Top module: `canid_filter`

## Requirements
- R1: After reset all code and mask bytes are 0, and `accept`, `rx_flag_set` and `hit_idx` are 0. With these values, in mode 00, only the identifier 0 is accepted, and it reports filter 0.
- R2: A mask bit of 1 makes the matching identifier bit a don't-care. A mask bit of 0 requires the identifier bit to equal the code bit.
- R3: In mode 00 (wide), filter b (b = 0,1) compares register bytes 4b..4b+3 with identifier bytes 0..3.
- R4: In mode 01 (half), filter 2b+h compares register bytes 4b+2h and 4b+2h+1 with identifier bytes 0 and 1. Identifier bytes 2 and 3 have no effect.
- R5: In mode 10 (narrow), filter k (k = 0..7) compares register byte k with identifier byte 0 only.
- R6: In mode 11 (closed), no frame is accepted and `rx_flag_set` never rises.
- R7: When several filters match, `hit_idx` reports the lowest-numbered one.
- R8: `accept` and `rx_flag_set` rise for exactly one cycle, in the cycle after a strobe whose frame matched. `hit_idx` is valid in that cycle and is 0 in every cycle where `accept` is low.
- R9: A write with `cfg_we` high stores `cfg_wdata` only while `init_mode` is high. `cfg_addr` selects register byte 0..7, and `cfg_sel` selects code (0) or mask (1). Writes while `init_mode` is low are ignored.
- R10: Without a frame-valid strobe, `accept` stays low whatever `id_word` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_mode | input | 1 | Enables writes to code and mask bytes |
| cfg_we | input | 1 | Write strobe for code/mask storage |
| cfg_sel | input | 1 | 0 selects code byte, 1 selects mask byte |
| cfg_addr | input | 3 | Register byte index 0..7 (bit 2 = bank) |
| cfg_wdata | input | 8 | Byte to store |
| filt_mode | input | 2 | 00 wide, 01 half, 10 narrow, 11 closed |
| frame_valid | input | 1 | One-cycle strobe: id_word holds a new header |
| id_word | input | 32 | Identifier bytes 0..3, byte 0 in bits 7:0 |
| accept | output | 1 | One-cycle accept pulse |
| hit_idx | output | 3 | Lowest matching filter number |
| rx_flag_set | output | 1 | Request to set the receive-full flag |

## Verification
A corrupted code or mask byte shows up on the first frame that reaches that filter. The result is then a wrong accept or a missing one, visible one clock after the strobe. A wrong grouping of bytes into filters shows as a wrong `hit_idx` on the first frame that matches only through the misrouted byte. A faulty priority encoder shows only when two filters match at once, so the sweep forces frames that copy code bytes from several registers. A write-lock fault stays hidden until a later frame meets the altered byte, so every locked write is followed at once by a probing frame.

// File: rtl/canf_pkg.sv
package canf_pkg;
  localparam int BANK_BYTES = 4;

  typedef logic [7:0] byte_t;

  typedef enum logic [1:0] {
    FM_WIDE    = 2'b00,
    FM_HALF    = 2'b01,
    FM_NARROW  = 2'b10,
    FM_CLOSED  = 2'b11
  } fmode_e;

  // one identifier byte against one code byte, masked bits ignored
  function automatic logic byte_hit(input byte_t id_b, input byte_t code_b, input byte_t mask_b);
    return ((id_b ^ code_b) & ~mask_b) == 8'h00;
  endfunction

  // number of live filters for a mode, given the bank count
  function automatic int filters_in_mode(input fmode_e m, input int nbank);
    case (m)
      FM_WIDE:   return nbank;
      FM_HALF:   return 2 * nbank;
      FM_NARROW: return BANK_BYTES * nbank;
      default:   return 0;
    endcase
  endfunction
endpackage

// File: rtl/canf_regs.sv
module canf_regs #(
  parameter int NREG = 8,
  localparam int AW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_mode,
  input  logic              we,
  input  logic              sel,
  input  logic [AW-1:0]     addr,
  input  logic [7:0]        wdata,
  output logic [NREG*8-1:0] code_flat,
  output logic [NREG*8-1:0] mask_flat
);
  logic wr_ok;
  assign wr_ok = we && init_mode;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        code_flat[r*8 +: 8] <= 8'h00;
        mask_flat[r*8 +: 8] <= 8'h00;
      end else if (wr_ok && addr == AW'(r)) begin
        if (sel) mask_flat[r*8 +: 8] <= wdata;
        else     code_flat[r*8 +: 8] <= wdata;
      end
    end
  end
endmodule

// File: rtl/canf_bank.sv
module canf_bank
  import canf_pkg::*;
(
  input  fmode_e      mode,
  input  logic [31:0] code_b,
  input  logic [31:0] mask_b,
  input  logic [31:0] id_word,
  output logic [3:0]  hits
);
  logic [3:0] full_m;
  logic [3:0] first_m;
  logic [3:0] second_m;
  logic [1:0] half_m;

  for (genvar j = 0; j < BANK_BYTES; j++) begin : g_byte
    // byte j of the header against register byte j (wide filter)
    assign full_m[j]   = byte_hit(id_word[j*8 +: 8], code_b[j*8 +: 8], mask_b[j*8 +: 8]);
    // header byte 0 against register byte j (narrow filters, first half byte)
    assign first_m[j]  = byte_hit(id_word[7:0],      code_b[j*8 +: 8], mask_b[j*8 +: 8]);
    // header byte 1 against register byte j (second byte of a half filter)
    assign second_m[j] = byte_hit(id_word[15:8],     code_b[j*8 +: 8], mask_b[j*8 +: 8]);
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half_m[h] = first_m[2*h] && second_m[2*h+1];
  end

  always_comb begin
    case (mode)
      FM_WIDE:   hits = {3'b000, &full_m};
      FM_HALF:   hits = {2'b00, half_m};
      FM_NARROW: hits = first_m;
      default:   hits = 4'b0000;
    endcase
  end
endmodule

// File: rtl/canf_prio.sv
module canf_prio #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/canid_filter.sv
module canid_filter
  import canf_pkg::*;
#(
  parameter int NBANK = 2,
  localparam int NREG  = NBANK * BANK_BYTES,
  localparam int NFILT = NBANK * BANK_BYTES,
  localparam int AW    = $clog2(NREG),
  localparam int HW    = $clog2(NFILT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_mode,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_addr,
  input  logic [7:0]    cfg_wdata,
  input  logic [1:0]    filt_mode,
  input  logic          frame_valid,
  input  logic [31:0]   id_word,
  output logic          accept,
  output logic [HW-1:0] hit_idx,
  output logic          rx_flag_set
);
  fmode_e mode;
  assign mode = fmode_e'(filt_mode);

  logic [NREG*8-1:0] code_flat;
  logic [NREG*8-1:0] mask_flat;
  logic [3:0]        bank_hits [NBANK];
  logic [NFILT-1:0]  hit_vec;
  logic              any_hit;
  logic [HW-1:0]     lowest_idx;
  logic              take;

  canf_regs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .we(cfg_we),
    .sel(cfg_sel), .addr(cfg_addr), .wdata(cfg_wdata),
    .code_flat(code_flat), .mask_flat(mask_flat)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    canf_bank u_bank (
      .mode(mode),
      .code_b(code_flat[b*32 +: 32]),
      .mask_b(mask_flat[b*32 +: 32]),
      .id_word(id_word),
      .hits(bank_hits[b])
    );
  end

  // place each bank's hits at the global filter number for the mode
  always_comb begin
    hit_vec = '0;
    for (int b = 0; b < NBANK; b++) begin
      case (mode)
        FM_WIDE: hit_vec[b] = bank_hits[b][0];
        FM_HALF: begin
          hit_vec[2*b]   = bank_hits[b][0];
          hit_vec[2*b+1] = bank_hits[b][1];
        end
        FM_NARROW: begin
          for (int k = 0; k < BANK_BYTES; k++)
            hit_vec[BANK_BYTES*b+k] = bank_hits[b][k];
        end
        default: ;
      endcase
    end
  end

  canf_prio #(.N(NFILT)) u_prio (.req(hit_vec), .any(any_hit), .idx(lowest_idx));

  assign take = frame_valid && any_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept      <= 1'b0;
      rx_flag_set <= 1'b0;
      hit_idx     <= '0;
    end else begin
      accept      <= take;
      rx_flag_set <= take;
      hit_idx     <= take ? lowest_idx : '0;
    end
  end
endmodule

// File: rtl/canid_filter_chk.sv
module canid_filter_chk #(
  parameter int NBANK = 2,
  parameter int NFILT = 8,
  parameter int HW = 3,
  parameter int NREG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_mode,
  input logic [1:0]        filt_mode,
  input logic              frame_valid,
  input logic              accept,
  input logic              rx_flag_set,
  input logic [HW-1:0]     hit_idx,
  input logic [NFILT-1:0]  hit_vec,
  input logic              any_hit,
  input logic [HW-1:0]     lowest_idx,
  input logic [NREG*8-1:0] code_flat,
  input logic [NREG*8-1:0] mask_flat
);
  // R6
  closed_never_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && filt_mode == 2'b11) |=> (!accept && !rx_flag_set));

  // R10
  no_strobe_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> (!accept && !rx_flag_set && hit_idx == '0));

  // R8
  accept_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && any_hit) |=> (accept && rx_flag_set && hit_idx == $past(lowest_idx)));

  // R9
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_mode |=> ($stable(code_flat) && $stable(mask_flat)));

  // R7
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (hit_vec[lowest_idx] &&
                 ((hit_vec & ((NFILT'(1) << lowest_idx) - NFILT'(1))) == '0)));

  // R3
  wide_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && filt_mode == 2'b00) |=> (int'(hit_idx) < NBANK));
endmodule

bind canid_filter canid_filter_chk #(
  .NBANK(NBANK), .NFILT(NFILT), .HW(HW), .NREG(NREG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .filt_mode(filt_mode),
  .frame_valid(frame_valid), .accept(accept), .rx_flag_set(rx_flag_set),
  .hit_idx(hit_idx), .hit_vec(hit_vec), .any_hit(any_hit),
  .lowest_idx(lowest_idx), .code_flat(code_flat), .mask_flat(mask_flat)
);

// File: tb/canid_filter_test.sv
`timescale 1ns/1ps
module canid_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_mode = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [1:0]  filt_mode = 2'b00;
  logic        frame_valid = 1'b0;
  logic [31:0] id_word = '0;
  logic        accept;
  logic [2:0]  hit_idx;
  logic        rx_flag_set;

  int total = 0;
  int fails = 0;
  logic [7:0] mcode [8];
  logic [7:0] mmask [8];

  always #2.5 clk = ~clk;

  canid_filter uut (
    .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .filt_mode(filt_mode), .frame_valid(frame_valid), .id_word(id_word),
    .accept(accept), .hit_idx(hit_idx), .rx_flag_set(rx_flag_set)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bit-by-bit reference, independent of any byte-wide xor trick
  function automatic bit ref_byte(input int r, input logic [7:0] idb);
    for (int b = 0; b < 8; b++)
      if (!mmask[r][b] && (mcode[r][b] != idb[b])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit ref_filter(input logic [1:0] md, input int f, input logic [31:0] id);
    bit ok = 1'b1;
    case (md)
      2'b00: for (int j = 0; j < 4; j++) ok = ok && ref_byte(4*f + j, id[8*j +: 8]);
      2'b01: for (int j = 0; j < 2; j++) ok = ok && ref_byte(4*(f/2) + 2*(f%2) + j, id[8*j +: 8]);
      2'b10: ok = ref_byte(f, id[7:0]);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  task automatic ref_eval(input logic [1:0] md, input logic [31:0] id, output bit acc, output int idx);
    int nf;
    nf = (md == 2'b00) ? 2 : (md == 2'b01) ? 4 : (md == 2'b10) ? 8 : 0;
    acc = 1'b0;
    idx = 0;
    for (int f = nf - 1; f >= 0; f--)
      if (ref_filter(md, f, id)) begin acc = 1'b1; idx = f; end
  endtask

  task automatic wr(input bit sel, input int a, input logic [7:0] d, input bit init);
    @(negedge clk);
    init_mode = init; cfg_we = 1'b1; cfg_sel = sel; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; init_mode = 1'b0;
    if (init) begin
      if (sel) mmask[a] = d; else mcode[a] = d;
    end
  endtask

  // one frame; the result is registered at the edge between the two negedges
  task automatic frame(input logic [1:0] md, input logic [31:0] id, input string req);
    bit acc;
    int idx;
    ref_eval(md, id, acc, idx);
    @(negedge clk);
    filt_mode = md; id_word = id; frame_valid = 1'b1;
    @(negedge clk);
    frame_valid = 1'b0;
    chk(accept == acc, req, int'(accept), int'(acc));
    chk(rx_flag_set == acc, req, int'(rx_flag_set), int'(acc));
    chk(int'(hit_idx) == (acc ? idx : 0), req, int'(hit_idx), acc ? idx : 0);
  endtask

  initial begin
    #1ms;
    fails++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int r = 0; r < 8; r++) begin mcode[r] = 8'h00; mmask[r] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!accept && !rx_flag_set && hit_idx == 3'd0, "R1", int'(accept), 0);
    frame(2'b00, 32'h0000_0000, "R1");
    frame(2'b00, 32'h0000_0100, "R1");

    // R10 header change with no strobe
    @(negedge clk); id_word = 32'h0; filt_mode = 2'b00;
    @(negedge clk);
    chk(!accept, "R10", int'(accept), 0);

    // R2 mask semantics: don't-care bit 3 of byte 0 in bank 1
    wr(1'b0, 4, 8'hA5, 1'b1); wr(1'b1, 4, 8'h08, 1'b1);
    for (int r = 5; r < 8; r++) wr(1'b1, r, 8'hFF, 1'b1);
    for (int r = 0; r < 4; r++) wr(1'b0, r, 8'h11, 1'b1);
    frame(2'b00, 32'h0000_00AD, "R2");
    frame(2'b00, 32'h0000_00A4, "R2");

    // R7 priority: bank 0 and bank 1 both matching, filter 0 wins
    for (int r = 0; r < 4; r++) wr(1'b1, r, 8'hFF, 1'b1);
    frame(2'b00, 32'h1234_56A5, "R7");
    // R8 pulse is single cycle
    @(negedge clk);
    chk(!accept && hit_idx == 3'd0, "R8", int'(accept), 0);

    // R9 locked write ignored: code byte 4 rewrite without init
    for (int r = 0; r < 4; r++) wr(1'b1, r, 8'h00, 1'b1);
    wr(1'b0, 4, 8'h5A, 1'b0);
    frame(2'b00, 32'h0000_00A5, "R9");
    frame(2'b00, 32'h0000_005A, "R9");
    wr(1'b0, 4, 8'h5A, 1'b1);
    frame(2'b00, 32'h0000_005A, "R9");

    // R4 upper bytes ignored in half mode
    wr(1'b0, 0, 8'h3C, 1'b1); wr(1'b0, 1, 8'hC3, 1'b1);
    frame(2'b01, 32'hFFFF_C33C, "R4");
    frame(2'b01, 32'h0000_C33C, "R4");

    // R6 closed: identifier that matches in every other mode
    for (int r = 0; r < 8; r++) wr(1'b1, r, 8'hFF, 1'b1);
    frame(2'b11, 32'h0000_0000, "R6");

    // sweep: every mode, many configurations, headers built from code bytes
    for (int md = 0; md < 4; md++) begin
      for (int cfg = 0; cfg < 24; cfg++) begin
        for (int r = 0; r < 8; r++) begin
          wr(1'b0, r, 8'($urandom), 1'b1);
          wr(1'b1, r, (cfg % 4 == 0) ? 8'h00 : 8'($urandom & $urandom & $urandom), 1'b1);
        end
        for (int t = 0; t < 8; t++) begin
          logic [31:0] id;
          int src;
          id = $urandom;
          src = $urandom % 8;
          if (t % 4 != 3) begin
            for (int j = 0; j < 4; j++) begin
              int r = (md == 1) ? ((src & 6) + j % 2 + (j / 2) * 2) % 8 : (src + j) % 8;
              id[8*j +: 8] = mcode[r] ^ (8'($urandom) & mmask[r]);
            end
          end
          case (md)
            0: frame(2'(md), id, "R3");
            1: frame(2'(md), id, "R4");
            2: frame(2'(md), id, "R5");
            default: frame(2'(md), id, "R6");
          endcase
        end
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule